// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wakeup

This block receives asynchronous serial frames on a single line shared by several stations. Each frame carries eight data bits, then one extra flag bit that marks the frame as an address, then a stop bit. The receiver samples the line at sixteen times the bit rate. It builds each frame in a shift register and hands finished frames to a data register. It keeps sticky status flags and raises two interrupt requests: one for data ready and one for errors.

For multidrop use, the host can arm a wakeup filter while multidrop mode is on. While the filter is armed, frames whose address bit is 0 are thrown away without any trace. The first frame whose address bit is 1 disarms the filter in hardware, sets the address flag, and is processed like any other frame. The host controls the block with level inputs and one-cycle strobes. A separate divider input sets the sample rate.

Top module: `mpr_rx`

## Requirements
- R1: With reception enabled, a low level on the line starts a frame. The start is kept only if the line is still low at the 8th sample of the start bit. A shorter low pulse returns the receiver to idle and produces no frame.
- R2: Data bits arrive least significant bit first. Each bit is taken at the 8th of its 16 samples. An accepted frame loads `rx_data` and sets `data_full`.
- R3: A stop bit sampled low sets `frame_err` for that frame. The data is still loaded.
- R4: If a frame is accepted while `data_full` is 1, `overrun_err` is set and `rx_data` keeps its old value.
- R5: While `mp_mode` and `wake_arm` are both 1, a frame with address bit 0 changes no output. No data is loaded, `data_full`, `frame_err` and `overrun_err` are not set, and neither interrupt rises.
- R6: A frame with address bit 1 received in `mp_mode` sets `addr_flag` and is accepted normally. If `wake_arm` was 1, it clears `wake_arm`.
- R7: With `mp_mode` at 0, the value of `wake_arm` has no effect, and frames with address bit 0 are accepted.
- R8: `wake_arm_set` sets `wake_arm` and `wake_arm_clr` clears it. If both strobes come in the same cycle, the set takes effect.
- R9: While `rx_enable` is 0, no frame is received and all status flags and `rx_data` keep their values.
- R10: Each of `clr_full`, `clr_frame_err`, `clr_overrun` and `clr_addr` clears its own flag one cycle after the strobe.
- R11: `irq_rx` equals `irq_enable` AND `data_full`. `irq_err` equals `irq_enable` AND (`frame_err` OR `overrun_err`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line; idles high |
| baud_div | input | 16 | Clocks per oversample tick (0 is treated as 1) |
| rx_enable | input | 1 | Receiver enable |
| mp_mode | input | 1 | Multidrop mode select |
| irq_enable | input | 1 | Enable for both interrupt requests |
| wake_arm_set | input | 1 | Strobe that arms the wakeup filter |
| wake_arm_clr | input | 1 | Strobe that disarms the wakeup filter |
| clr_full | input | 1 | Strobe that clears data_full |
| clr_frame_err | input | 1 | Strobe that clears frame_err |
| clr_overrun | input | 1 | Strobe that clears overrun_err |
| clr_addr | input | 1 | Strobe that clears addr_flag |
| rx_data | output | 8 | Last accepted data byte |
| data_full | output | 1 | Unread data present |
| frame_err | output | 1 | Stop bit was low |
| overrun_err | output | 1 | Frame arrived while data was unread |
| addr_flag | output | 1 | Address frame received in multidrop mode |
| wake_arm | output | 1 | Wakeup filter armed |
| irq_rx | output | 1 | Data-ready interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench sends a frame with address bit 0 and a bad stop bit while the filter is armed. A design that filtered too late would set `frame_err` or replace the data here. It then sends an address frame. A design that did not disarm in hardware would drop every later frame, and one that skipped the address flag would leave `addr_flag` low. A second frame sent while the data register is still full must leave the old byte in place; a design that overwrote it would lose the unread value. A short low glitch must produce nothing, or the design would accept false starts. The bench also toggles `mp_mode` with the filter still armed, and drops `rx_enable` during traffic, to catch filters and flags that respond when they should be inert.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mpr_tick.sv
module mpr_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        tick    = 1'b0;
        cnt_d   = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q >= div_eff - DIV_W'(1)) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mpr_deframer.sv
module mpr_deframer
    import mpr_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 line,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 mpb,
    output logic                 stop_ok
);
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int CNT_W      = $clog2(OVERSAMPLE);
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int MID        = OVERSAMPLE / 2 - 1;
    localparam int LAST       = OVERSAMPLE - 1;

    typedef struct packed {
        rx_state_e            state;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS:0]   shreg;
        logic                 done;
        logic                 stop_ok;
    } df_t;

    df_t df_d, df_q;

    always_comb begin
        df_d      = df_q;
        df_d.done = 1'b0;
        if (!en) begin
            df_d.state = RX_IDLE;
            df_d.cnt   = '0;
            df_d.idx   = '0;
        end else if (tick) begin
            case (df_q.state)
                RX_IDLE: begin
                    if (!line) begin
                        df_d.state = RX_START;
                        df_d.cnt   = CNT_W'(1);
                    end
                end
                RX_START: begin
                    if (df_q.cnt == CNT_W'(MID)) begin
                        df_d.cnt = '0;
                        df_d.idx = '0;
                        df_d.state = line ? RX_IDLE : RX_BITS;
                    end else begin
                        df_d.cnt = df_q.cnt + CNT_W'(1);
                    end
                end
                RX_BITS: begin
                    if (df_q.cnt == CNT_W'(LAST)) begin
                        df_d.cnt = '0;
                        if (df_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                            df_d.stop_ok = line;
                            df_d.done    = 1'b1;
                            df_d.state   = RX_IDLE;
                        end else begin
                            df_d.shreg = {line, df_q.shreg[DATA_BITS:1]};
                            df_d.idx   = df_q.idx + IDX_W'(1);
                        end
                    end else begin
                        df_d.cnt = df_q.cnt + CNT_W'(1);
                    end
                end
                default: df_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            df_q         <= '0;
            df_q.state   <= RX_IDLE;
            df_q.stop_ok <= 1'b1;
        end else begin
            df_q <= df_d;
        end
    end

    assign done    = df_q.done;
    assign data    = df_q.shreg[DATA_BITS-1:0];
    assign mpb     = df_q.shreg[DATA_BITS];
    assign stop_ok = df_q.stop_ok;
endmodule

// File: rtl/mpr_rx.sv
module mpr_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic [DIV_W-1:0]     baud_div,
    input  logic                 rx_enable,
    input  logic                 mp_mode,
    input  logic                 irq_enable,
    input  logic                 wake_arm_set,
    input  logic                 wake_arm_clr,
    input  logic                 clr_full,
    input  logic                 clr_frame_err,
    input  logic                 clr_overrun,
    input  logic                 clr_addr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_full,
    output logic                 frame_err,
    output logic                 overrun_err,
    output logic                 addr_flag,
    output logic                 wake_arm,
    output logic                 irq_rx,
    output logic                 irq_err
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 full;
        logic                 fe;
        logic                 ov;
        logic                 addr;
        logic                 arm;
    } stat_t;

    logic                 line_s;
    logic                 tick;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_mpb;
    logic                 frm_stop_ok;
    logic                 filtered;
    logic                 accept;
    stat_t                st_d, st_q;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
    );

    mpr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(rx_enable), .div(baud_div), .tick(tick)
    );

    mpr_deframer #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_deframer (
        .clk(clk), .rst_n(rst_n), .en(rx_enable), .tick(tick), .line(line_s),
        .done(frm_done), .data(frm_data), .mpb(frm_mpb), .stop_ok(frm_stop_ok)
    );

    always_comb begin
        filtered = mp_mode && st_q.arm && !frm_mpb;
        accept   = frm_done && !filtered;
        st_d     = st_q;

        if (clr_full)      st_d.full = 1'b0;
        if (clr_frame_err) st_d.fe   = 1'b0;
        if (clr_overrun)   st_d.ov   = 1'b0;
        if (clr_addr)      st_d.addr = 1'b0;
        if (wake_arm_clr)  st_d.arm  = 1'b0;
        if (wake_arm_set)  st_d.arm  = 1'b1;

        if (accept) begin
            if (mp_mode && frm_mpb) begin
                st_d.addr = 1'b1;
                st_d.arm  = 1'b0;
            end
            if (st_q.full && !clr_full) begin
                st_d.ov = 1'b1;
            end else begin
                st_d.data = frm_data;
                st_d.full = 1'b1;
            end
            if (!frm_stop_ok) st_d.fe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data     = st_q.data;
    assign data_full   = st_q.full;
    assign frame_err   = st_q.fe;
    assign overrun_err = st_q.ov;
    assign addr_flag   = st_q.addr;
    assign wake_arm    = st_q.arm;
    assign irq_rx      = irq_enable && st_q.full;
    assign irq_err     = irq_enable && (st_q.fe || st_q.ov);
endmodule

// File: rtl/mpr_rx_checker.sv
module mpr_rx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_enable,
    input logic                 mp_mode,
    input logic                 wake_arm_set,
    input logic                 wake_arm_clr,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 data_full,
    input logic                 frame_err,
    input logic                 wake_arm,
    input logic                 f_done,
    input logic                 f_mpb
);
    assert_keep_unread_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> !$past(data_full));

    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rx_enable) && !rx_enable) |=> (!$rose(data_full) && !$rose(frame_err)));

    assert_discard_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(f_done) && !$past(f_mpb) && $past(mp_mode) && $past(wake_arm))
        |-> (!$rose(data_full) && !$rose(frame_err)));

    assert_arm_only_by_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_arm) |-> $past(wake_arm_set));

    assert_disarm_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_arm) |-> ($past(wake_arm_clr) || ($past(f_done) && $past(f_mpb))));
endmodule

bind mpr_rx mpr_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .mp_mode(mp_mode),
    .wake_arm_set(wake_arm_set), .wake_arm_clr(wake_arm_clr),
    .rx_data(rx_data), .data_full(data_full), .frame_err(frame_err),
    .wake_arm(wake_arm), .f_done(frm_done), .f_mpb(frm_mpb)
);

// File: tb/tb_mpr_rx.sv
`timescale 1ns/1ps
module tb_mpr_rx;
    localparam int BIT_CLKS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [15:0] baud_div = 16'd2;
    logic       rx_enable = 1'b0, mp_mode = 1'b0, irq_enable = 1'b1;
    logic       wake_arm_set = 1'b0, wake_arm_clr = 1'b0;
    logic       clr_full = 1'b0, clr_frame_err = 1'b0, clr_overrun = 1'b0, clr_addr = 1'b0;
    logic [7:0] rx_data;
    logic       data_full, frame_err, overrun_err, addr_flag, wake_arm, irq_rx, irq_err;

    int checks = 0, errors = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural expectation
    logic [7:0] m_data = 8'h00;
    bit m_full = 0, m_fe = 0, m_ov = 0, m_addr = 0, m_arm = 0;

    always #5 clk = ~clk;

    mpr_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div),
        .rx_enable(rx_enable), .mp_mode(mp_mode), .irq_enable(irq_enable),
        .wake_arm_set(wake_arm_set), .wake_arm_clr(wake_arm_clr),
        .clr_full(clr_full), .clr_frame_err(clr_frame_err),
        .clr_overrun(clr_overrun), .clr_addr(clr_addr),
        .rx_data(rx_data), .data_full(data_full), .frame_err(frame_err),
        .overrun_err(overrun_err), .addr_flag(addr_flag), .wake_arm(wake_arm),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "rx_data", int'(rx_data), int'(m_data));
        chk(req, "data_full", int'(data_full), int'(m_full));
        chk(req, "frame_err", int'(frame_err), int'(m_fe));
        chk(req, "overrun_err", int'(overrun_err), int'(m_ov));
        chk(req, "addr_flag", int'(addr_flag), int'(m_addr));
        chk(req, "wake_arm", int'(wake_arm), int'(m_arm));
        chk(req, "irq_rx", int'(irq_rx), int'(irq_enable && m_full));
        chk(req, "irq_err", int'(irq_err), int'(irq_enable && (m_fe || m_ov)));
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // model of one complete frame at the ports
    task automatic model_frame(input logic [7:0] d, input bit mpb, input bit stop_hi);
        if (!rx_enable) return;
        if (mp_mode && m_arm && !mpb) return;
        if (mp_mode && mpb) begin
            m_addr = 1;
            m_arm = 0;
        end
        if (m_full) m_ov = 1;
        else begin
            m_data = d;
            m_full = 1;
        end
        if (!stop_hi) m_fe = 1;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit mpb, input bit stop_hi);
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            wait_clks(BIT_CLKS);
        end
        rxd = mpb;
        wait_clks(BIT_CLKS);
        rxd = stop_hi;
        wait_clks(stop_hi ? BIT_CLKS : 24);
        rxd = 1'b1;
        wait_clks(60);
        model_frame(d, mpb, stop_hi);
    endtask

    task automatic clear_flags(input bit f, input bit fe, input bit ov, input bit a);
        @(negedge clk);
        clr_full = f; clr_frame_err = fe; clr_overrun = ov; clr_addr = a;
        @(negedge clk);
        clr_full = 0; clr_frame_err = 0; clr_overrun = 0; clr_addr = 0;
        if (f) m_full = 0;
        if (fe) m_fe = 0;
        if (ov) m_ov = 0;
        if (a) m_addr = 0;
        wait_clks(1);
    endtask

    task automatic arm_strobe(input bit s, input bit c);
        @(negedge clk);
        wake_arm_set = s; wake_arm_clr = c;
        @(negedge clk);
        wake_arm_set = 0; wake_arm_clr = 0;
        if (c) m_arm = 0;
        if (s) m_arm = 1;
        wait_clks(1);
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        check_all("reset");
        rx_enable = 1'b1;
        wait_clks(4);

        // R2 plain reception, R11 data interrupt
        send_frame(8'hA5, 0, 1);
        check_all("R2");
        // R4 overrun keeps old data, R11 error interrupt
        send_frame(8'h3C, 0, 1);
        check_all("R4");
        // R10 clears
        clear_flags(1, 0, 1, 0);
        check_all("R10");
        // R3 framing error
        send_frame(8'h5A, 0, 0);
        check_all("R3");
        clear_flags(1, 1, 0, 0);
        check_all("R10");

        // R1 short low pulse is a false start
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(8);
        rxd = 1'b1;
        wait_clks(BIT_CLKS * 12);
        check_all("R1");

        // R8 arm the filter, R7 multidrop mode off so it is inert
        arm_strobe(1, 0);
        check_all("R8");
        send_frame(8'h11, 0, 1);
        check_all("R7");
        clear_flags(1, 0, 0, 0);

        // R5 armed filter drops plain frames, even with a bad stop bit
        mp_mode = 1'b1;
        send_frame(8'h22, 0, 0);
        check_all("R5");
        // R6 address frame wakes the receiver
        send_frame(8'h80, 1, 1);
        check_all("R6");
        clear_flags(1, 0, 0, 0);
        send_frame(8'h33, 0, 1);
        check_all("R6");

        // R9 disabled receiver ignores traffic and keeps flags
        rx_enable = 1'b0;
        wait_clks(2);
        send_frame(8'h44, 1, 0);
        check_all("R9");
        rx_enable = 1'b1;
        wait_clks(4);

        // R11 interrupts follow the enable
        irq_enable = 1'b0;
        wait_clks(1);
        check_all("R11");
        irq_enable = 1'b1;

        // R10 address flag clear
        clear_flags(1, 0, 0, 1);
        check_all("R10");

        // R8 clear strobe, then both strobes together
        arm_strobe(1, 0);
        arm_strobe(0, 1);
        check_all("R8");
        arm_strobe(1, 1);
        check_all("R8");

        finish_run();
    end
endmodule